// File: doc/BRIEF.md
# Sync Period Meter

This block measures how long the horizontal and vertical sync periods are, so a controller can tell which video mode is arriving. Each axis has its own start strobe. After a start, the horizontal channel waits for a leading (rising) edge of the line sync. It then counts reference ticks until a fixed number of further line periods have passed. With the default of 64 lines and a tick of one thirty-second of an 8 MHz clock (250 kHz), the result reads as 16000 divided by the line rate in kHz. For example, 40 kHz gives 0x190 and 100 kHz gives 0x0A0.

The vertical channel works the same way over one frame period. Its tick is one five-hundred-twelfth of the system clock (15.625 kHz), so the result is 15625 divided by the frame rate in Hz; 60 Hz gives 0x104. When the final edge arrives, a done flag rises and the result is held until the next start. A clock-select input halves both dividers when the system clock runs at 4 MHz instead of 8 MHz, so the result scaling stays the same.

Top module: `sync_period_meter`

## Requirements
- R1: While `rst` is high and on the cycle after it, both results read 0 and both done flags read 0.
- R2: A start strobe sampled high clears that channel's done flag and result on the next clock, and aborts any measurement in progress. The measurement then re-arms and waits for a new leading edge.
- R3: The horizontal result equals floor((T-1)/D), where T is the number of clocks between the arming leading edge of `hsync` and the H_LINES-th following leading edge, and D is H_DIV.
- R4: The vertical result equals floor((T-1)/D), where T is the number of clocks between two consecutive leading edges of `vsync`, and D is V_DIV.
- R5: With `clk_is_4m` at 1, both dividers are halved (D = H_DIV/2, D = V_DIV/2).
- R6: The done flag rises on the clock that samples the final leading edge. After that, the result and the flag hold steady despite further sync edges until the next start.
- R7: A count that reaches all ones (2047 horizontal, 511 vertical) stays there, and the done flag still rises at the final edge.
- R8: Sync edges seen while no measurement is armed or running have no effect on results or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Internal line sync, positive polarity |
| vsync | input | 1 | Internal frame sync, positive polarity |
| h_start | input | 1 | Start strobe for the horizontal measurement |
| v_start | input | 1 | Start strobe for the vertical measurement |
| clk_is_4m | input | 1 | 1 selects halved dividers for a 4 MHz clock |
| h_count | output | H_W | Horizontal result |
| h_done | output | 1 | Horizontal measurement finished |
| v_count | output | V_W | Vertical result |
| v_done | output | 1 | Vertical measurement finished |

## Verification
Some properties are checked by assertions on every cycle:
- a start clears the flag and the count;
- the count never decreases while a measurement runs, and stays pinned once it saturates;
- a finished result holds steady;
- the flag rises only on a leading edge.

Other behaviour can only be shown by the bench's scenarios: the exact tick totals for given periods, the halving under clock select, the abort-and-rearm of a restart, and saturation followed by completion. For these, the bench compares a behavioural model against both channels on every clock.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;
endpackage

// File: rtl/spm_rise_detect.sv
module spm_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/spm_tick_div.sv
module spm_tick_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic half,
  output logic tick
);
  localparam int PW = $clog2(DIV);
  localparam logic [PW-1:0] LIM_FULL = PW'(DIV - 1);
  localparam logic [PW-1:0] LIM_HALF = PW'(DIV / 2 - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] lim;

  assign lim  = half ? LIM_HALF : LIM_FULL;
  assign tick = ~hold && (phase_q == lim);

  always_ff @(posedge clk) begin
    if (rst || hold)        phase_q <= '0;
    else if (phase_q >= lim) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/spm_period_counter.sv
module spm_period_counter
  import spm_pkg::*;
#(
  parameter int PERIODS = 64,
  parameter int DIV     = 32,
  parameter int W       = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync_in,
  input  logic         start,
  input  logic         half,
  output logic [W-1:0] count,
  output logic         done
);
  localparam int LW = $clog2(PERIODS + 1);
  localparam logic [LW-1:0] LAST = LW'(PERIODS - 1);
  localparam logic [W-1:0]  CMAX = {W{1'b1}};

  phase_t        phase_q;
  logic [LW-1:0] seen_q;
  logic          rise;
  logic          tick;

  spm_rise_detect u_edge (
    .clk(clk), .rst(rst), .sig_in(sync_in), .rise(rise)
  );

  spm_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst(rst), .hold(phase_q != PH_RUN), .half(half), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      seen_q  <= '0;
      count   <= '0;
      done    <= 1'b0;
    end else if (start) begin
      phase_q <= PH_ARMED;
      seen_q  <= '0;
      count   <= '0;
      done    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_ARMED: if (rise) begin
          phase_q <= PH_RUN;
          seen_q  <= '0;
          count   <= '0;
        end
        PH_RUN: begin
          if (rise && seen_q == LAST) begin
            phase_q <= PH_IDLE;
            done    <= 1'b1;
          end else begin
            if (rise) seen_q <= seen_q + 1'b1;
            if (tick && count != CMAX) count <= count + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: a start clears flag and result on the next clock
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && count == '0));

  // R3/R4: the count never decreases during a run
  a_r3_monotonic: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN && !start) |=> (count >= $past(count)));

  // R6: a finished result holds until the next start
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(count)));

  // R6: the flag rises only on the sampled leading edge
  a_r6_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(rise));

  // R7: a saturated count stays at all ones
  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !start) |=> (count == CMAX));
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter #(
  parameter int H_PERIODS = 64,
  parameter int H_DIV     = 32,
  parameter int H_W       = 11,
  parameter int V_DIV     = 512,
  parameter int V_W       = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hsync,
  input  logic           vsync,
  input  logic           h_start,
  input  logic           v_start,
  input  logic           clk_is_4m,
  output logic [H_W-1:0] h_count,
  output logic           h_done,
  output logic [V_W-1:0] v_count,
  output logic           v_done
);
  spm_period_counter #(.PERIODS(H_PERIODS), .DIV(H_DIV), .W(H_W)) u_h (
    .clk(clk), .rst(rst), .sync_in(hsync), .start(h_start),
    .half(clk_is_4m), .count(h_count), .done(h_done)
  );

  spm_period_counter #(.PERIODS(1), .DIV(V_DIV), .W(V_W)) u_v (
    .clk(clk), .rst(rst), .sync_in(vsync), .start(v_start),
    .half(clk_is_4m), .count(v_count), .done(v_done)
  );
endmodule

// File: tb/tb_sync_period_meter.sv
module tb_sync_period_meter;
  localparam int HP = 4, HD = 8, HW = 11, VD = 16, VW = 9;

  logic clk = 0, rst = 1;
  logic hsync = 0, vsync = 0, h_start = 0, v_start = 0, sel4 = 0;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;
  logic h_done, v_done;

  sync_period_meter #(.H_PERIODS(HP), .H_DIV(HD), .H_W(HW), .V_DIV(VD), .V_W(VW)) dut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .h_start(h_start),
    .v_start(v_start), .clk_is_4m(sel4), .h_count(h_count), .h_done(h_done),
    .v_count(v_count), .v_done(v_done)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int hper = 100, vper = 300;
  int hc = 0, vc = 0;

  // Sync generators, driven away from the active edge
  always @(negedge clk) begin
    hc = (hc + 1 >= hper) ? 0 : hc + 1;
    vc = (vc + 1 >= vper) ? 0 : vc + 1;
    hsync <= (hc < 3);
    vsync <= (vc < 5);
  end

  // Behavioural model: ch 0 = horizontal, 1 = vertical
  int m_ph[2], m_k[2], m_edges[2], m_res[2], m_prev[2];
  bit m_done[2];

  function automatic int mlimit(int ch);
    return ch == 0 ? 2047 : 511;
  endfunction

  always @(posedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      int inp, st, edge_s, need, dv;
      inp    = ch == 0 ? int'(hsync) : int'(vsync);
      st     = ch == 0 ? int'(h_start) : int'(v_start);
      need   = ch == 0 ? HP : 1;
      dv     = (ch == 0 ? HD : VD) / (sel4 ? 2 : 1);
      edge_s = (inp == 1 && m_prev[ch] == 0) ? 1 : 0;
      if (rst) begin
        m_ph[ch] = 0; m_res[ch] = 0; m_done[ch] = 0; m_prev[ch] = 0;
      end else begin
        if (st == 1) begin
          m_ph[ch] = 1; m_res[ch] = 0; m_done[ch] = 0;
        end else if (m_ph[ch] == 1 && edge_s == 1) begin
          m_ph[ch] = 2; m_k[ch] = 0; m_edges[ch] = 0;
        end else if (m_ph[ch] == 2) begin
          m_k[ch]++;
          if (edge_s == 1) m_edges[ch]++;
          if (m_edges[ch] == need) begin
            m_ph[ch] = 0; m_done[ch] = 1;
            m_res[ch] = (m_k[ch] - 1) / dv;
            if (m_res[ch] > mlimit(ch)) m_res[ch] = mlimit(ch);
          end
        end
        m_prev[ch] = inp;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R3, R4, R6, R8)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 h_done model", int'(h_done), int'(m_done[0]));
      chk("R6 v_done model", int'(v_done), int'(m_done[1]));
      if (m_ph[0] != 2) chk("R3 h_count model", int'(h_count), m_res[0]);
      if (m_ph[1] != 2) chk("R4 v_count model", int'(v_count), m_res[1]);
    end
  end

  task automatic pulse_h();
    @(negedge clk); h_start <= 1; @(negedge clk); h_start <= 0;
  endtask
  task automatic pulse_v();
    @(negedge clk); v_start <= 1; @(negedge clk); v_start <= 0;
  endtask
  task automatic wait_h();
    int n = 0;
    while (!h_done && n < 60000) begin @(negedge clk); n++; end
  endtask
  task automatic wait_v();
    int n = 0;
    while (!v_done && n < 60000) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 h_count reset", int'(h_count), 0);
    chk("R1 flags reset", int'(h_done) + int'(v_done), 0);
    rst <= 0;
    @(negedge clk);
    chk("R1 v_count after reset", int'(v_count), 0);
    // R8: edges while idle leave everything at zero
    repeat (400) @(negedge clk);
    chk("R8 idle h_count", int'(h_count), 0);
    chk("R8 idle v_done", int'(v_done), 0);

    // R3: 4 lines of 100 clocks -> floor(399/8)=49
    pulse_h(); wait_h(); @(negedge clk);
    chk("R3 h result", int'(h_count), 49);
    // R6: hold across more edges
    repeat (500) @(negedge clk);
    chk("R6 h hold", int'(h_count), 49);
    chk("R6 h flag hold", int'(h_done), 1);

    // R4: frame of 300 clocks -> floor(299/16)=18
    pulse_v(); wait_v(); @(negedge clk);
    chk("R4 v result", int'(v_count), 18);

    // R5: halved dividers -> 99 and 37
    sel4 <= 1;
    pulse_h(); wait_h(); @(negedge clk);
    chk("R5 h result 4m", int'(h_count), 99);
    pulse_v(); wait_v(); @(negedge clk);
    chk("R5 v result 4m", int'(v_count), 37);
    sel4 <= 0;

    // R2: restart mid-run, new period applies
    pulse_h(); repeat (150) @(negedge clk);
    chk("R2 no done mid-run", int'(h_done), 0);
    hper = 60; hc = 0;
    pulse_h();
    chk("R2 cleared", int'(h_count) + int'(h_done), 0);
    wait_h(); @(negedge clk);
    chk("R2 restart result", int'(h_count), 29);

    // R7: vertical saturation, period 9000 -> 511
    vper = 9000; vc = 0;
    pulse_v(); wait_v(); @(negedge clk);
    chk("R7 v saturated", int'(v_count), 511);
    chk("R7 v done", int'(v_done), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule